// File: doc/BRIEF.md
# Writeback Port Slot Allocator

This block places completing instructions into writeback cycles when only a fixed number of result-bus ports exist per cycle. It keeps a rolling window of future cycles. Each window position records how many ports are already claimed in that cycle and which entries hold them. A completion claims the earliest future cycle that still has a free port. Several completions in one cycle are placed one after another in lane order, and each lane sees the claims of the lanes before it.

Every cycle the oldest window position is drained onto the writeback outputs, at most one entry per port, in the order the entries claimed it. A drained entry that was squashed still uses its port but produces nothing. A live entry raises its ready flag, which marks it as result-ready and commit-eligible. It also raises its wake flag, but only if it actually executed. A completion pushed past the next cycle raises a late pulse on its lane. A completion that finds the whole window full is dropped and sets a sticky overflow flag. The window then advances by one position and the freed position re-enters empty at the far end.

Top module: `wb_slot_alloc`

## Requirements
- R1: While reset is asserted and right after it, every ready, wake and tag output is zero, and the overflow flag is low.
- R2: A single completion arriving while the window is empty appears on port 0 in the next cycle with its tag, and raises no late pulse.
- R3: A writeback cycle carries at most WB_W entries. Completions in one cycle claim ports in ascending lane order, and port index within a cycle follows claim order.
- R4: A completion claims the earliest window position with a free port. Position p (0 to DEPTH-1) means writeback p+1 cycles after the completion cycle, and positions filled by earlier cycles count.
- R5: `late_o[l]` is high, in the same cycle as the completion on lane l, exactly when that completion was placed at a position other than 0.
- R6: The window holds DEPTH positions, so a completion can be delayed by up to DEPTH-1 extra cycles. Up to DEPTH*WB_W entries may be outstanding.
- R7: A completion that finds all DEPTH positions full is discarded and `ovf_o` rises on the next cycle. It stays high until reset.
- R8: A drained entry whose squash flag was set uses its port, but its ready, wake and tag outputs stay zero.
- R9: A drained live entry raises ready. It raises wake only if its executed flag was set.
- R10: Once all claimed entries have drained, the outputs return to zero and the full capacity of every position is available again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_v | input | LANES | Completion valid per lane |
| cmp_tag | input | LANES*TAG_W | Completion tag per lane, lane l at bits [l*TAG_W +: TAG_W] |
| cmp_sq | input | LANES | Completion is squashed |
| cmp_ex | input | LANES | Completion has executed |
| wb_ready | output | WB_W | Port carries a live entry, now result-ready and commit-eligible |
| wb_wake | output | WB_W | Port requests a dependent wakeup |
| wb_tag | output | WB_W*TAG_W | Tag per port, port j at bits [j*TAG_W +: TAG_W], zero when not ready |
| late_o | output | LANES | Lane's completion was placed beyond the next cycle |
| ovf_o | output | 1 | Sticky window overflow |

## Verification
The hardest case to reach is a completion that finds every position of the window already taken. This needs a backlog that is deeper than the window, while the entries already in flight keep draining. The stimulus builds it with back-to-back cycles in which all lanes complete together. These cycles claim twice the port width per cycle, so the queue grows until the far position is full and a lane is dropped. Before that, bursts that only partly fill the window check that late lanes land in the right later cycle, and in the right port order behind earlier claims.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

  // Outcome of one lane's claim attempt in the current cycle.
  typedef enum logic [1:0] {
    LN_IDLE   = 2'd0,
    LN_ONTIME = 2'd1,
    LN_LATE   = 2'd2,
    LN_DROP   = 2'd3
  } lane_fate_e;

  // A drained port is result-ready when it holds a live entry.
  function automatic logic port_ready(input logic occupied, input logic squashed);
    return occupied & ~squashed;
  endfunction

  // A drained port wakes dependents only if the entry executed.
  function automatic logic port_wake(input logic occupied, input logic squashed,
                                     input logic executed);
    return occupied & ~squashed & executed;
  endfunction

  function automatic logic fate_claims(input lane_fate_e f);
    return (f == LN_ONTIME) || (f == LN_LATE);
  endfunction

endpackage

// File: rtl/wbs_alloc.sv
module wbs_alloc
  import wbs_pkg::*;
#(
  parameter int LANES = 4,
  parameter int WB_W  = 2,
  parameter int DEPTH = 5,
  parameter int CNT_W = 2,
  parameter int POS_W = 3,
  parameter int WAY_W = 1
) (
  input  logic [LANES-1:0]             req_v,
  input  logic [DEPTH-1:0][CNT_W-1:0]  pos_cnt,
  output logic [LANES-1:0][POS_W-1:0]  lane_pos,
  output logic [LANES-1:0][WAY_W-1:0]  lane_way,
  output lane_fate_e [LANES-1:0]       lane_fate
);

  // Sequential first-fit over lanes: each lane sees earlier lanes' claims.
  always_comb begin : first_fit
    logic [DEPTH-1:0][CNT_W-1:0] run;
    logic found;
    run = pos_cnt;
    found = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      lane_pos[l]  = '0;
      lane_way[l]  = '0;
      lane_fate[l] = LN_IDLE;
      found = 1'b0;
      if (req_v[l]) begin
        for (int p = 0; p < DEPTH; p++) begin
          if (!found && (run[p] < CNT_W'(WB_W))) begin
            found       = 1'b1;
            lane_pos[l] = POS_W'(p);
            lane_way[l] = WAY_W'(run[p]);
            run[p]      = run[p] + 1'b1;
          end
        end
        if (!found)
          lane_fate[l] = LN_DROP;
        else if (lane_pos[l] == '0)
          lane_fate[l] = LN_ONTIME;
        else
          lane_fate[l] = LN_LATE;
      end
    end
  end

endmodule

// File: rtl/wbs_window.sv
module wbs_window
  import wbs_pkg::*;
#(
  parameter int LANES = 4,
  parameter int WB_W  = 2,
  parameter int DEPTH = 5,
  parameter int TAG_W = 6,
  parameter int CNT_W = 2,
  parameter int POS_W = 3,
  parameter int WAY_W = 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [LANES-1:0][POS_W-1:0]        lane_pos,
  input  logic [LANES-1:0][WAY_W-1:0]        lane_way,
  input  lane_fate_e [LANES-1:0]             lane_fate,
  input  logic [LANES-1:0][TAG_W-1:0]        lane_tag,
  input  logic [LANES-1:0]                   lane_sq,
  input  logic [LANES-1:0]                   lane_ex,
  output logic [DEPTH-1:0][CNT_W-1:0]        pos_cnt,
  output logic [CNT_W-1:0]                   head_cnt,
  output logic [WB_W-1:0][TAG_W-1:0]         head_tag,
  output logic [WB_W-1:0]                    head_sq,
  output logic [WB_W-1:0]                    head_ex,
  output logic                               win_empty
);

  // Slot 0 drains this cycle; slot i+1 becomes slot i at the next edge.
  logic [DEPTH-1:0][CNT_W-1:0]            cnt_q,  cnt_n,  sh_cnt;
  logic [DEPTH-1:0][WB_W-1:0][TAG_W-1:0]  tag_q,  tag_n,  sh_tag;
  logic [DEPTH-1:0][WB_W-1:0]             sq_q,   sq_n,   sh_sq;
  logic [DEPTH-1:0][WB_W-1:0]             ex_q,   ex_n,   sh_ex;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_shift
    if (gi < DEPTH - 1) begin : g_mid
      assign sh_cnt[gi] = cnt_q[gi+1];
      assign sh_tag[gi] = tag_q[gi+1];
      assign sh_sq[gi]  = sq_q[gi+1];
      assign sh_ex[gi]  = ex_q[gi+1];
    end else begin : g_far
      // Slot re-entering at the far end starts empty.
      assign sh_cnt[gi] = '0;
      assign sh_tag[gi] = '0;
      assign sh_sq[gi]  = '0;
      assign sh_ex[gi]  = '0;
    end
  end

  assign pos_cnt   = sh_cnt;
  assign head_cnt  = cnt_q[0];
  assign head_tag  = tag_q[0];
  assign head_sq   = sq_q[0];
  assign head_ex   = ex_q[0];
  assign win_empty = (cnt_q == '0);

  always_comb begin : merge_claims
    cnt_n = sh_cnt;
    tag_n = sh_tag;
    sq_n  = sh_sq;
    ex_n  = sh_ex;
    for (int i = 0; i < DEPTH; i++) begin
      for (int l = 0; l < LANES; l++) begin
        if (fate_claims(lane_fate[l]) && (lane_pos[l] == POS_W'(i))) begin
          tag_n[i][lane_way[l]] = lane_tag[l];
          sq_n[i][lane_way[l]]  = lane_sq[l];
          ex_n[i][lane_way[l]]  = lane_ex[l];
          cnt_n[i]              = cnt_n[i] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tag_q <= '0;
      sq_q  <= '0;
      ex_q  <= '0;
    end else begin
      cnt_q <= cnt_n;
      tag_q <= tag_n;
      sq_q  <= sq_n;
      ex_q  <= ex_n;
    end
  end

endmodule

// File: rtl/wbs_drain.sv
module wbs_drain
  import wbs_pkg::*;
#(
  parameter int WB_W  = 2,
  parameter int TAG_W = 6,
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0]             head_cnt,
  input  logic [WB_W-1:0][TAG_W-1:0]   head_tag,
  input  logic [WB_W-1:0]              head_sq,
  input  logic [WB_W-1:0]              head_ex,
  output logic [WB_W-1:0]              port_rdy,
  output logic [WB_W-1:0]              port_wake,
  output logic [WB_W-1:0][TAG_W-1:0]   port_tag
);

  for (genvar gj = 0; gj < WB_W; gj++) begin : g_port
    logic occupied;
    assign occupied      = CNT_W'(gj) < head_cnt;
    assign port_rdy[gj]  = port_ready(occupied, head_sq[gj]);
    assign port_wake[gj] = wbs_pkg::port_wake(occupied, head_sq[gj], head_ex[gj]);
    assign port_tag[gj]  = port_rdy[gj] ? head_tag[gj] : '0;
  end

endmodule

// File: rtl/wb_slot_alloc.sv
module wb_slot_alloc
  import wbs_pkg::*;
#(
  parameter int LANES = 4,
  parameter int WB_W  = 2,
  parameter int DEPTH = 5,
  parameter int TAG_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LANES-1:0]         cmp_v,
  input  logic [LANES*TAG_W-1:0]   cmp_tag,
  input  logic [LANES-1:0]         cmp_sq,
  input  logic [LANES-1:0]         cmp_ex,
  output logic [WB_W-1:0]          wb_ready,
  output logic [WB_W-1:0]          wb_wake,
  output logic [WB_W*TAG_W-1:0]    wb_tag,
  output logic [LANES-1:0]         late_o,
  output logic                     ovf_o
);

  localparam int CNT_W = $clog2(WB_W + 1);
  localparam int POS_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int WAY_W = (WB_W > 1) ? $clog2(WB_W) : 1;

  logic [LANES-1:0][TAG_W-1:0]   lane_tag;
  logic [LANES-1:0][POS_W-1:0]   lane_pos;
  logic [LANES-1:0][WAY_W-1:0]   lane_way;
  lane_fate_e [LANES-1:0]        lane_fate;
  logic [DEPTH-1:0][CNT_W-1:0]   pos_cnt;
  logic [CNT_W-1:0]              head_cnt;
  logic [WB_W-1:0][TAG_W-1:0]    head_tag;
  logic [WB_W-1:0]               head_sq;
  logic [WB_W-1:0]               head_ex;
  logic [WB_W-1:0][TAG_W-1:0]    port_tag;
  logic                          win_empty;
  logic                          miss_any;
  logic                          ovf_q;

  assign lane_tag = cmp_tag;

  wbs_alloc #(
    .LANES(LANES), .WB_W(WB_W), .DEPTH(DEPTH),
    .CNT_W(CNT_W), .POS_W(POS_W), .WAY_W(WAY_W)
  ) u_alloc (
    .req_v     (cmp_v),
    .pos_cnt   (pos_cnt),
    .lane_pos  (lane_pos),
    .lane_way  (lane_way),
    .lane_fate (lane_fate)
  );

  wbs_window #(
    .LANES(LANES), .WB_W(WB_W), .DEPTH(DEPTH), .TAG_W(TAG_W),
    .CNT_W(CNT_W), .POS_W(POS_W), .WAY_W(WAY_W)
  ) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .lane_pos  (lane_pos),
    .lane_way  (lane_way),
    .lane_fate (lane_fate),
    .lane_tag  (lane_tag),
    .lane_sq   (cmp_sq),
    .lane_ex   (cmp_ex),
    .pos_cnt   (pos_cnt),
    .head_cnt  (head_cnt),
    .head_tag  (head_tag),
    .head_sq   (head_sq),
    .head_ex   (head_ex),
    .win_empty (win_empty)
  );

  wbs_drain #(
    .WB_W(WB_W), .TAG_W(TAG_W), .CNT_W(CNT_W)
  ) u_drain (
    .head_cnt  (head_cnt),
    .head_tag  (head_tag),
    .head_sq   (head_sq),
    .head_ex   (head_ex),
    .port_rdy  (wb_ready),
    .port_wake (wb_wake),
    .port_tag  (port_tag)
  );

  assign wb_tag = port_tag;

  always_comb begin
    miss_any = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      late_o[l] = (lane_fate[l] == LN_LATE);
      if (lane_fate[l] == LN_DROP) miss_any = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_q | miss_any;
  end

  assign ovf_o = ovf_q;

endmodule

// File: rtl/wbs_chk.sv
module wbs_chk #(
  parameter int LANES = 4,
  parameter int WB_W  = 2,
  parameter int TAG_W = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [LANES-1:0]       cmp_v,
  input logic [LANES*TAG_W-1:0] cmp_tag,
  input logic [LANES-1:0]       cmp_sq,
  input logic [WB_W-1:0]        wb_ready,
  input logic [WB_W-1:0]        wb_wake,
  input logic [WB_W*TAG_W-1:0]  wb_tag,
  input logic [LANES-1:0]       late_o,
  input logic                   ovf_o,
  input logic                   win_empty,
  input logic                   miss_any
);

  // R2
  lone_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_v == LANES'(1) && !cmp_sq[0] && win_empty)
      |=> (wb_ready[0] && wb_tag[TAG_W-1:0] == $past(cmp_tag[TAG_W-1:0])));

  // R5
  late_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (late_o & ~cmp_v) == '0);

  // R7
  drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_any |=> ovf_o);

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);

  // R9
  wake_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_wake & ~wb_ready) == '0);

endmodule

bind wb_slot_alloc wbs_chk #(
  .LANES(LANES), .WB_W(WB_W), .TAG_W(TAG_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmp_v     (cmp_v),
  .cmp_tag   (cmp_tag),
  .cmp_sq    (cmp_sq),
  .wb_ready  (wb_ready),
  .wb_wake   (wb_wake),
  .wb_tag    (wb_tag),
  .late_o    (late_o),
  .ovf_o     (ovf_o),
  .win_empty (win_empty),
  .miss_any  (miss_any)
);

// File: tb/sim_wb_slot_alloc.sv
`timescale 1ns/1ps
module sim_wb_slot_alloc;

  localparam int LANES = 4;
  localparam int WB_W  = 2;
  localparam int DEPTH = 5;
  localparam int TAG_W = 6;
  localparam int MAXC  = 1024;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [LANES-1:0]       cmp_v = '0;
  logic [LANES*TAG_W-1:0] cmp_tag = '0;
  logic [LANES-1:0]       cmp_sq = '0;
  logic [LANES-1:0]       cmp_ex = '0;
  logic [WB_W-1:0]        wb_ready;
  logic [WB_W-1:0]        wb_wake;
  logic [WB_W*TAG_W-1:0]  wb_tag;
  logic [LANES-1:0]       late_o;
  logic                   ovf_o;

  always #10 clk = ~clk;

  wb_slot_alloc #(.LANES(LANES), .WB_W(WB_W), .DEPTH(DEPTH), .TAG_W(TAG_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmp_v(cmp_v), .cmp_tag(cmp_tag), .cmp_sq(cmp_sq),
    .cmp_ex(cmp_ex), .wb_ready(wb_ready), .wb_wake(wb_wake), .wb_tag(wb_tag),
    .late_o(late_o), .ovf_o(ovf_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model: per absolute writeback cycle, a list of claimed entries.
  int             m_cnt [MAXC];
  logic [TAG_W-1:0] m_tag [MAXC*WB_W];
  bit             m_sq  [MAXC*WB_W];
  bit             m_ex  [MAXC*WB_W];
  bit             m_ovf = 1'b0;
  int             k = 0;
  string          cur_req = "R2";

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s cycle=%0d actual=%0h expected=%0h", req, what, k, act, exp);
    end
  endtask

  task automatic step(input logic [LANES-1:0] v, input logic [LANES*TAG_W-1:0] tags,
                      input logic [LANES-1:0] sq, input logic [LANES-1:0] ex);
    logic [WB_W-1:0] e_rdy, e_wake;
    logic [WB_W*TAG_W-1:0] e_tag;
    logic [LANES-1:0] e_late;
    bit drop;
    @(negedge clk);
    // compare the writeback outputs of cycle k
    e_rdy = '0; e_wake = '0; e_tag = '0;
    for (int j = 0; j < WB_W; j++) begin
      if (j < m_cnt[k] && !m_sq[k*WB_W+j]) begin
        e_rdy[j] = 1'b1;
        e_wake[j] = m_ex[k*WB_W+j];
        e_tag[j*TAG_W +: TAG_W] = m_tag[k*WB_W+j];
      end
    end
    check(cur_req, "wb_ready", int'(wb_ready), int'(e_rdy));
    check(cur_req, "wb_wake",  int'(wb_wake),  int'(e_wake));
    check(cur_req, "wb_tag",   int'(wb_tag),   int'(e_tag));
    check("R7", "ovf_o", int'(ovf_o), int'(m_ovf));
    // drive this cycle's completions and allocate them in the model
    cmp_v = v; cmp_tag = tags; cmp_sq = sq; cmp_ex = ex;
    #1;
    e_late = '0;
    drop = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (v[l]) begin
        bit found = 1'b0;
        for (int p = 0; p < DEPTH; p++) begin
          int c = k + 1 + p;
          if (!found && m_cnt[c] < WB_W) begin
            m_tag[c*WB_W + m_cnt[c]] = tags[l*TAG_W +: TAG_W];
            m_sq[c*WB_W + m_cnt[c]]  = sq[l];
            m_ex[c*WB_W + m_cnt[c]]  = ex[l];
            m_cnt[c]++;
            found = 1'b1;
            e_late[l] = (p != 0);
          end
        end
        if (!found) drop = 1'b1;
      end
    end
    check("R5", "late_o", int'(late_o), int'(e_late));
    if (drop) m_ovf = 1'b1;
    k++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step('0, '0, '0, '0);
  endtask

  function automatic logic [LANES*TAG_W-1:0] pack4(input int a, input int b,
                                                   input int c, input int d);
    return {TAG_W'(d), TAG_W'(c), TAG_W'(b), TAG_W'(a)};
  endfunction

  initial begin : watchdog
    #(20 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", "reset wb_ready", int'(wb_ready), 0);
    check("R1", "reset wb_wake",  int'(wb_wake),  0);
    check("R1", "reset wb_tag",   int'(wb_tag),   0);
    check("R1", "reset ovf_o",    int'(ovf_o),    0);
    rst_n = 1'b1;
    k = 0;

    // R2: lone executed completion, next cycle on port 0
    cur_req = "R2";
    step(4'b0001, pack4(5, 0, 0, 0), '0, 4'b0001);
    idle(2);
    // R9: ready without wake when not executed
    cur_req = "R9";
    step(4'b0010, pack4(0, 9, 0, 0), '0, '0);
    idle(2);
    // R8: squashed entry consumes port silently
    cur_req = "R8";
    step(4'b0001, pack4(12, 0, 0, 0), 4'b0001, 4'b0001);
    idle(1);
    step(4'b0011, pack4(13, 14, 0, 0), 4'b0001, 4'b0011);
    idle(2);
    // R3: four lanes at once, two on time, two late in lane order
    cur_req = "R3";
    step(4'b1111, pack4(1, 2, 3, 4), '0, 4'b1111);
    idle(3);
    // R4: backlog from earlier cycles pushes later claims back
    cur_req = "R4";
    for (int i = 0; i < 3; i++)
      step(4'b0111, pack4(20 + 3*i, 21 + 3*i, 22 + 3*i, 0), 4'b0100, 4'b0111);
    step(4'b1000, pack4(0, 0, 0, 40), '0, 4'b1000);
    // R10: drain completely, capacity returns
    cur_req = "R10";
    idle(DEPTH + 2);
    step(4'b0011, pack4(41, 42, 0, 0), '0, 4'b0011);
    idle(2);
    // R6: mixed traffic, at most two lanes per cycle
    cur_req = "R6";
    for (int i = 0; i < 200; i++) begin
      logic [LANES-1:0] v;
      v = LANES'($urandom) & ((i % 2) ? 4'b0011 : 4'b1100);
      step(v, LANES*TAG_W'($urandom), LANES'($urandom), LANES'($urandom));
    end
    idle(DEPTH + 2);
    check("R7", "ovf before flood", int'(ovf_o), 0);
    // R6/R7: flood all lanes until the window overflows
    cur_req = "R6";
    for (int i = 0; i < 8; i++)
      step(4'b1111, pack4(4*i, 4*i + 1, 4*i + 2, 4*i + 3), '0, 4'b1111);
    cur_req = "R10";
    idle(DEPTH + 3);
    check("R7", "ovf sticky after drain", int'(ovf_o), 1);
    check("R10", "empty ready after drain", int'(wb_ready), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule